// File: doc/BRIEF.md
# Dual-Rail Pipelined Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns the 16-bit product. All data is carried in dual-rail code: each bit has two wires, so a word shows whether it holds a value or is empty. Consecutive operand pairs must be separated by an all-empty (NULL) word. The datapath is an array of full-adder cells. Each cell forms its own partial-product AND term and works in carry-save form. Registers cut the array into four pipeline stages. A register takes a new wavefront only when its input word is complete and the register after it asks for that phase. The request and acknowledge handshake runs on a sampling clock. It is evaluated once per edge and places no timing constraint on the data path.

Each register (16, 30, 30, 21 and 16 dual-rail bits, from input to output) runs a two-state machine. In `REG_WANT_DATA` it asks for DATA. It moves to `REG_WANT_NULL` when its input is complete DATA and its successor asks for DATA. It returns when its input is all NULL and its successor asks for NULL. Each stage's logic has a gate machine with two states. It moves from `GATE_ASLEEP` to `GATE_AWAKE` when the stage input is complete DATA and the register after the stage asks for DATA. It moves back when the stage input is all NULL and that register asks for NULL. While asleep, every logic output is forced to NULL. This replaces the stage's NULL phase, and nothing held downstream is lost.

The environment drives operands, watches `in_ko` for when to switch between DATA and NULL, and acknowledges results through `out_ki`.

Top module: `dr_mul_array`

## Requirements
- R1: Every dual-rail bit is a pair {rail1, rail0} with rail1 at the odd position: 2'b01 is logic 0, 2'b10 is logic 1, 2'b00 is NULL and 2'b11 is illegal. Operand and product bit i sits at positions [2i+1:2i].
- R2: While reset is high, and after it is released with no input applied, `in_ko` is 1 and `prod_dr` is all NULL.
- R3: For every operand pair, the DATA word delivered on `prod_dr` decodes to the unsigned product x*y.
- R4: The input register does not accept a word in which any bit is NULL (`in_ko` stays 1). After it accepts a complete word, `in_ko` stays 0 for as long as the inputs remain DATA.
- R5: Once `prod_dr` holds DATA, it stays unchanged while `out_ki` stays 1.
- R6: After `out_ki` goes to 0, `prod_dr` returns to all NULL. It stays NULL while `out_ki` remains 0.
- R7: A stage's logic is forced to NULL when its input word is NULL and the register after it asks for NULL. It is released only once its input is complete DATA and that register asks for DATA. Products leave in the order their operands entered, and none is lost or repeated.
- R8: No dual-rail bit on any register output or stage logic output ever takes the illegal code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the handshake evaluation |
| rst | input | 1 | Active-high reset; all registers NULL, all request DATA |
| x_dr | input | 16 | Operand x, 8 dual-rail bits |
| y_dr | input | 16 | Operand y, 8 dual-rail bits |
| in_ko | output | 1 | 1: input register asks for DATA; 0: asks for NULL |
| prod_dr | output | 32 | Product, 16 dual-rail bits |
| out_ki | input | 1 | Consumer request: 1 asks for DATA, 0 asks for NULL |

## Verification
The interesting coincidence is a stage falling asleep in the same cycle that the register after it takes the NULL wavefront. The opposite case also matters: a register can take new DATA while the stage behind it is still sleeping off the previous token. The bench provokes both by running producer and consumer concurrently. The producer pauses on some tokens and the consumer stalls on others, with and without acknowledging. Every product is compared in order against x*y. During the stalls the output is watched for stability, and after each acknowledge it is watched for a clean return to NULL.

// File: rtl/dr_mul_pkg.sv
package dr_mul_pkg;

    localparam int OP_W      = 8;
    localparam int PROD_W    = 2 * OP_W;
    localparam int ROWS_STG  = 3;
    localparam int CS_W      = OP_W - 1;
    localparam int R0_W      = 2 * OP_W;
    localparam int R1_W      = OP_W + (OP_W - ROWS_STG) + ROWS_STG + 2 * CS_W;
    localparam int R2_W      = R1_W;
    localparam int R3_W      = (OP_W + 2) + 2 * (CS_W - 2) + 1;
    localparam int R4_W      = PROD_W;

    typedef logic [1:0] dr_bit_t;

    localparam dr_bit_t DR_NULL = 2'b00;
    localparam dr_bit_t DR_ZERO = 2'b01;
    localparam dr_bit_t DR_ONE  = 2'b10;
    localparam logic [2*CS_W-1:0] DR_ZERO_CS = {CS_W{DR_ZERO}};

    typedef enum logic {REG_WANT_DATA, REG_WANT_NULL} reg_state_e;
    typedef enum logic {GATE_ASLEEP, GATE_AWAKE} gate_state_e;

    function automatic logic dr_valid(input dr_bit_t b);
        return (b == DR_ZERO) || (b == DR_ONE);
    endfunction

    function automatic dr_bit_t dr_enc(input logic v);
        return v ? DR_ONE : DR_ZERO;
    endfunction

    function automatic dr_bit_t dr_and(input dr_bit_t a, input dr_bit_t b);
        return (dr_valid(a) && dr_valid(b)) ? dr_enc(a[1] & b[1]) : DR_NULL;
    endfunction

    // returns {carry, sum}; NULL unless all inputs hold DATA
    function automatic logic [3:0] dr_fa(input dr_bit_t a, input dr_bit_t b, input dr_bit_t c);
        logic s;
        logic co;
        if (dr_valid(a) && dr_valid(b) && dr_valid(c)) begin
            s  = a[1] ^ b[1] ^ c[1];
            co = (a[1] & b[1]) | (a[1] & c[1]) | (b[1] & c[1]);
            return {dr_enc(co), dr_enc(s)};
        end
        return 4'b0000;
    endfunction

    function automatic logic [3:0] dr_ha(input dr_bit_t a, input dr_bit_t b);
        if (dr_valid(a) && dr_valid(b))
            return {dr_enc(a[1] & b[1]), dr_enc(a[1] ^ b[1])};
        return 4'b0000;
    endfunction

    // One carry-save row with embedded AND terms.
    // Result: [1:0] finished product bit, [15:2] sum vector, [29:16] carry vector.
    function automatic logic [29:0] dr_row(input logic [2*OP_W-1:0] x, input dr_bit_t yk,
                                           input logic [2*CS_W-1:0] s_in,
                                           input logic [2*CS_W-1:0] c_in);
        logic [2*OP_W-1:0] t;
        logic [2*CS_W-1:0] c_out;
        logic [3:0]        fo;
        for (int i = 0; i < CS_W; i++) begin
            fo = dr_fa(dr_and(x[2*i+:2], yk), s_in[2*i+:2], c_in[2*i+:2]);
            t[2*i+:2]     = fo[1:0];
            c_out[2*i+:2] = fo[3:2];
        end
        t[2*OP_W-1:2*OP_W-2] = dr_and(x[2*OP_W-1:2*OP_W-2], yk);
        return {c_out, t};
    endfunction

endpackage

// File: rtl/dr_mul_logic.sv
module dr_mul_logic
    import dr_mul_pkg::*;
#(
    parameter int STAGE = 1,
    parameter int IN_W  = R0_W,
    parameter int OUT_W = R1_W
) (
    input  logic [2*IN_W-1:0]  din,
    output logic [2*OUT_W-1:0] dout
);

    if (STAGE == 1) begin : g_rows_012
        logic [29:0] r0, r1, r2;
        always_comb begin
            r0 = dr_row(din[15:0], din[17:16], DR_ZERO_CS, DR_ZERO_CS);
            r1 = dr_row(din[15:0], din[19:18], r0[15:2], r0[29:16]);
            r2 = dr_row(din[15:0], din[21:20], r1[15:2], r1[29:16]);
            dout[15:0]  = din[15:0];
            dout[25:16] = din[31:22];
            dout[27:26] = r0[1:0];
            dout[29:28] = r1[1:0];
            dout[31:30] = r2[1:0];
            dout[45:32] = r2[15:2];
            dout[59:46] = r2[29:16];
        end
    end else if (STAGE == 2) begin : g_rows_345
        logic [29:0] r3, r4, r5;
        always_comb begin
            r3 = dr_row(din[15:0], din[17:16], din[45:32], din[59:46]);
            r4 = dr_row(din[15:0], din[19:18], r3[15:2], r3[29:16]);
            r5 = dr_row(din[15:0], din[21:20], r4[15:2], r4[29:16]);
            dout[15:0]  = din[15:0];
            dout[19:16] = din[25:22];
            dout[25:20] = din[31:26];
            dout[27:26] = r3[1:0];
            dout[29:28] = r4[1:0];
            dout[31:30] = r5[1:0];
            dout[45:32] = r5[15:2];
            dout[59:46] = r5[29:16];
        end
    end else if (STAGE == 3) begin : g_rows_67
        logic [29:0] r6, r7;
        logic [3:0]  h, f;
        always_comb begin
            r6 = dr_row(din[15:0], din[17:16], din[45:32], din[59:46]);
            r7 = dr_row(din[15:0], din[19:18], r6[15:2], r6[29:16]);
            h  = dr_ha(r7[3:2], r7[17:16]);
            f  = dr_fa(r7[5:4], r7[19:18], h[3:2]);
            dout[11:0]  = din[31:20];
            dout[13:12] = r6[1:0];
            dout[15:14] = r7[1:0];
            dout[17:16] = h[1:0];
            dout[19:18] = f[1:0];
            dout[29:20] = r7[15:6];
            dout[39:30] = r7[29:20];
            dout[41:40] = f[3:2];
        end
    end else if (STAGE == 4) begin : g_final_add
        logic [3:0] fo;
        logic [1:0] c;
        always_comb begin
            dout[19:0] = din[19:0];
            c = din[41:40];
            for (int i = 0; i < CS_W - 2; i++) begin
                fo = dr_fa(din[20+2*i+:2], din[30+2*i+:2], c);
                dout[20+2*i+:2] = fo[1:0];
                c = fo[3:2];
            end
            dout[31:30] = c;
        end
    end else begin : g_none
        assign dout = '0;
    end

endmodule

// File: rtl/dr_reg.sv
module dr_reg
    import dr_mul_pkg::*;
#(
    parameter int W = R0_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2*W-1:0] d,
    input  logic           ki,
    output logic [2*W-1:0] q,
    output logic           ko
);

    function automatic logic all_data(input logic [2*W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < W; i++)
            if (!dr_valid(v[2*i+:2])) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic any_clash(input logic [2*W-1:0] v);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < W; i++)
            if (v[2*i+:2] == 2'b11) hit = 1'b1;
        return hit;
    endfunction

    reg_state_e state_q, state_d;
    logic       load;
    logic       d_full, d_empty, q_clash;

    assign d_full  = all_data(d);
    assign d_empty = (d == '0);
    assign q_clash = any_clash(q);

    always_ff @(posedge clk) begin
        if (rst) state_q <= REG_WANT_DATA;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            REG_WANT_DATA: if (d_full && ki) begin
                load    = 1'b1;
                state_d = REG_WANT_NULL;
            end
            REG_WANT_NULL: if (d_empty && !ki) begin
                load    = 1'b1;
                state_d = REG_WANT_DATA;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assign ko = (state_q == REG_WANT_DATA);

    // R8
    reg_rail_clash_chk: assert property (@(posedge clk) disable iff (rst) !q_clash);

    // R4
    reg_partial_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ko && !(d_full && ki)) |=> (ko && q == '0));

    // R5
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ko && !(d_empty && !ki)) |=> (!ko && $stable(q)));

endmodule

// File: rtl/dr_sleep_stage.sv
module dr_sleep_stage
    import dr_mul_pkg::*;
#(
    parameter int STAGE = 1,
    parameter int IN_W  = R0_W,
    parameter int OUT_W = R1_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*IN_W-1:0]  src_q,
    input  logic               dst_ko,
    output logic [2*OUT_W-1:0] dout,
    output logic               awake
);

    function automatic logic all_data(input logic [2*IN_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < IN_W; i++)
            if (!dr_valid(v[2*i+:2])) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic any_clash(input logic [2*OUT_W-1:0] v);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < OUT_W; i++)
            if (v[2*i+:2] == 2'b11) hit = 1'b1;
        return hit;
    endfunction

    gate_state_e        gate_q, gate_d;
    logic               src_full, src_empty, out_clash;
    logic [2*OUT_W-1:0] raw;

    assign src_full  = all_data(src_q);
    assign src_empty = (src_q == '0);

    always_ff @(posedge clk) begin
        if (rst) gate_q <= GATE_ASLEEP;
        else     gate_q <= gate_d;
    end

    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_ASLEEP: if (src_full && dst_ko)   gate_d = GATE_AWAKE;
            GATE_AWAKE:  if (src_empty && !dst_ko) gate_d = GATE_ASLEEP;
        endcase
    end

    dr_mul_logic #(.STAGE(STAGE), .IN_W(IN_W), .OUT_W(OUT_W)) u_logic (
        .din  (src_q),
        .dout (raw)
    );

    assign awake     = (gate_q == GATE_AWAKE);
    assign dout      = awake ? raw : '0;
    assign out_clash = any_clash(dout);

    // R8
    stage_rail_clash_chk: assert property (@(posedge clk) disable iff (rst) !out_clash);

    // R7
    stage_awake_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (awake && src_empty) |-> !dst_ko);

endmodule

// File: rtl/dr_mul_array.sv
module dr_mul_array
    import dr_mul_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2*OP_W-1:0]   x_dr,
    input  logic [2*OP_W-1:0]   y_dr,
    output logic                in_ko,
    output logic [2*PROD_W-1:0] prod_dr,
    input  logic                out_ki
);

    logic [2*R0_W-1:0] rq0;
    logic [2*R1_W-1:0] rq1, lg1;
    logic [2*R2_W-1:0] rq2, lg2;
    logic [2*R3_W-1:0] rq3, lg3;
    logic [2*R4_W-1:0] rq4, lg4;
    logic ko0, ko1, ko2, ko3, ko4;
    logic awk1, awk2, awk3, awk4;

    dr_reg #(.W(R0_W)) u_reg0 (.clk(clk), .rst(rst), .d({y_dr, x_dr}), .ki(ko1), .q(rq0), .ko(ko0));

    dr_sleep_stage #(.STAGE(1), .IN_W(R0_W), .OUT_W(R1_W)) u_stg1 (
        .clk(clk), .rst(rst), .src_q(rq0), .dst_ko(ko1), .dout(lg1), .awake(awk1));
    dr_reg #(.W(R1_W)) u_reg1 (.clk(clk), .rst(rst), .d(lg1), .ki(ko2), .q(rq1), .ko(ko1));

    dr_sleep_stage #(.STAGE(2), .IN_W(R1_W), .OUT_W(R2_W)) u_stg2 (
        .clk(clk), .rst(rst), .src_q(rq1), .dst_ko(ko2), .dout(lg2), .awake(awk2));
    dr_reg #(.W(R2_W)) u_reg2 (.clk(clk), .rst(rst), .d(lg2), .ki(ko3), .q(rq2), .ko(ko2));

    dr_sleep_stage #(.STAGE(3), .IN_W(R2_W), .OUT_W(R3_W)) u_stg3 (
        .clk(clk), .rst(rst), .src_q(rq2), .dst_ko(ko3), .dout(lg3), .awake(awk3));
    dr_reg #(.W(R3_W)) u_reg3 (.clk(clk), .rst(rst), .d(lg3), .ki(ko4), .q(rq3), .ko(ko3));

    dr_sleep_stage #(.STAGE(4), .IN_W(R3_W), .OUT_W(R4_W)) u_stg4 (
        .clk(clk), .rst(rst), .src_q(rq3), .dst_ko(ko4), .dout(lg4), .awake(awk4));
    dr_reg #(.W(R4_W)) u_reg4 (.clk(clk), .rst(rst), .d(lg4), .ki(out_ki), .q(rq4), .ko(ko4));

    assign in_ko   = ko0;
    assign prod_dr = rq4;

    // R7: a register only captures DATA from a stage that was awake
    wake_before_capture1_chk: assert property (@(posedge clk) disable iff (rst) $fell(ko1) |-> $past(awk1));
    // R7
    wake_before_capture2_chk: assert property (@(posedge clk) disable iff (rst) $fell(ko2) |-> $past(awk2));
    // R7
    wake_before_capture3_chk: assert property (@(posedge clk) disable iff (rst) $fell(ko3) |-> $past(awk3));
    // R7
    wake_before_capture4_chk: assert property (@(posedge clk) disable iff (rst) $fell(ko4) |-> $past(awk4));

endmodule

// File: tb/dr_mul_array_test.sv
module dr_mul_array_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_SWEEP    = 2048;
    localparam int N_RAND     = 400;
    localparam int TOTAL      = N_SWEEP + N_RAND;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] x_dr = '0;
    logic [15:0] y_dr = '0;
    logic        out_ki = 1'b1;
    logic        in_ko;
    logic [31:0] prod_dr;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  clash_seen = 1'b0;
    int  n_sent = 0;
    int  n_recv = 0;
    logic [15:0] exp_mem [0:TOTAL-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    dr_mul_array uut (
        .clk(clk), .rst(rst), .x_dr(x_dr), .y_dr(y_dr),
        .in_ko(in_ko), .prod_dr(prod_dr), .out_ki(out_ki)
    );

    function automatic logic [15:0] enc8(input logic [7:0] v);
        logic [15:0] r;
        for (int i = 0; i < 8; i++) r[2*i+:2] = v[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    function automatic bit p_all_data(input logic [31:0] v);
        for (int i = 0; i < 16; i++)
            if (v[2*i+:2] != 2'b01 && v[2*i+:2] != 2'b10) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [15:0] p_val(input logic [31:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[2*i+1];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // R8 monitor on the product rails
    always @(negedge clk) begin
        if (!rst)
            for (int i = 0; i < 16; i++)
                if (prod_dr[2*i+:2] == 2'b11) clash_seen = 1'b1;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d sent %0d received, expected %0d", n_sent, n_recv, TOTAL);
            summary();
            $finish;
        end
    end

    task automatic producer();
        logic [7:0] lfsr;
        lfsr = 8'h5D;
        for (int k = 0; k < TOTAL; k++) begin
            logic [7:0] xv, yv;
            logic [7:0] yset [8];
            yset = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd127, 8'd128, 8'd170, 8'd255};
            if (k < N_SWEEP) begin
                xv = k[7:0];
                yv = yset[k >> 8];
            end else begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                xv = lfsr;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                yv = lfsr;
            end
            while (!in_ko) @(negedge clk);
            exp_mem[n_sent] = 16'(xv) * 16'(yv);
            n_sent++;
            x_dr = enc8(xv);
            y_dr = enc8(yv);
            @(negedge clk);
            while (in_ko) @(negedge clk);
            x_dr = '0;
            y_dr = '0;
            @(negedge clk);
            if (n_sent % 5 == 0) repeat (9) @(negedge clk);
        end
    endtask

    task automatic consumer();
        logic [31:0] snap;
        int guard;
        while (n_recv < TOTAL) begin
            out_ki = 1'b1;
            @(negedge clk);
            while (!p_all_data(prod_dr)) @(negedge clk);
            // R3 R7: value and order of every product
            check(p_val(prod_dr) == exp_mem[n_recv], "R3 R7", "product in order",
                  {16'd0, p_val(prod_dr)}, {16'd0, exp_mem[n_recv]});
            if (n_recv % 7 == 3) begin
                snap = prod_dr;
                repeat (12) @(negedge clk);
                check(prod_dr == snap, "R5", "held product", prod_dr, snap);
            end
            out_ki = 1'b0;
            guard = 0;
            @(negedge clk);
            while (prod_dr != '0 && guard < 40) begin
                @(negedge clk);
                guard++;
            end
            check(prod_dr == '0, "R6", "return to NULL", prod_dr, 32'd0);
            if (n_recv % 11 == 4) begin
                repeat (10) @(negedge clk);
                check(prod_dr == '0, "R6", "NULL kept while acknowledge low", prod_dr, 32'd0);
            end
            n_recv++;
        end
    endtask

    initial begin
        int guard;
        logic [15:0] part_x;
        repeat (3) @(negedge clk);
        // R2
        check(in_ko == 1'b1, "R2", "in_ko during reset", {31'd0, in_ko}, 32'd1);
        check(prod_dr == '0, "R2", "product during reset", prod_dr, 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(in_ko == 1'b1 && prod_dr == '0, "R2", "idle after reset", {31'd0, in_ko}, 32'd1);

        // R4: incomplete operand (x bit 3 NULL) must not be accepted
        part_x = enc8(8'hA5);
        part_x[7:6] = 2'b00;
        x_dr = part_x;
        y_dr = enc8(8'h3C);
        repeat (10) @(negedge clk);
        check(in_ko == 1'b1, "R4", "partial word refused", {31'd0, in_ko}, 32'd1);
        check(prod_dr == '0, "R4", "no output from partial word", prod_dr, 32'd0);
        x_dr = enc8(8'hA5);
        guard = 0;
        while (in_ko && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        check(in_ko == 1'b0, "R4", "complete word accepted", {31'd0, in_ko}, 32'd0);
        repeat (20) @(negedge clk);
        check(in_ko == 1'b0, "R4", "request stays NULL while DATA held", {31'd0, in_ko}, 32'd0);
        guard = 0;
        while (!p_all_data(prod_dr) && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        // R1: both rails complementary on every product bit
        check(p_all_data(prod_dr), "R1", "rails complementary", prod_dr, 32'd0);
        check(p_val(prod_dr) == 16'h26AC, "R3", "A5 times 3C", {16'd0, p_val(prod_dr)}, 32'h26AC);
        x_dr = '0;
        y_dr = '0;
        out_ki = 1'b0;
        guard = 0;
        while (prod_dr != '0 && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        check(prod_dr == '0, "R6", "directed return to NULL", prod_dr, 32'd0);
        guard = 0;
        while (!in_ko && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        check(in_ko == 1'b1, "R4", "request DATA after NULL", {31'd0, in_ko}, 32'd1);

        fork
            producer();
            consumer();
        join

        // R7
        check(n_recv == n_sent, "R7", "token count", n_recv, n_sent);
        // R8
        check(!clash_seen, "R8", "no illegal rail pair", {31'd0, clash_seen}, 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule